// File: doc/BRIEF.md
# Two-Digit Multiplexed Hex Key Display

This block keeps the two most recently entered 4-bit key codes and shows them as hexadecimal glyphs on a pair of seven-segment digits. The digits share one bus of seven segment lines, and each digit has its own enable. That makes nine output pins in total. An upstream scanner and debouncer raise a one-cycle strobe for each accepted key. On that strobe, the code already held as newest moves into the older slot and the incoming code becomes the newest.

A free-running refresh divider switches between the two digits. At the default of 200000 cycles of a 48 MHz clock, the digit changes about every 4.2 ms. The segment lines always carry the glyph of the digit that is enabled at that moment. Digit 0 shows the newest key and digit 1 shows the one before it. Enables and segments are both active low, which suits digits whose supply is switched by transistors from the positive rail.

Top module: `keydisp_top`

## Requirements
- R1: While reset is held low at a clock edge, both history slots clear to code 0, digit 0 is selected (`dig_en_n` = 2'b10), and the segment bus shows the glyph for 0.
- R2: At a clock edge with `key_valid` high, the older slot takes the previous newest code and the newest slot takes `key_code`. Both updates happen at that same edge.
- R3: While `key_valid` is low, changes on `key_code` have no effect on either displayed digit.
- R4: When digit 0 is enabled, the segment bus shows the newest code. When digit 1 is enabled, it shows the older code.
- R5: Exactly one enable is low at every clock after reset. Bit 0 of `dig_en_n` enables digit 0 and bit 1 enables digit 1.
- R6: The enabled digit toggles once every `REFRESH_DIV` clock edges. The first toggle happens at the `REFRESH_DIV`-th edge after reset is released.
- R7: Segments are active low and ordered `seg_n[6:0]` = {g,f,e,d,c,b,a}. Codes 0–F give the usual hex glyphs, with lowercase b and d. Examples: 0→7'h40, 1→7'h79, A→7'h08, b→7'h03, d→7'h21, F→7'h0E.
- R8: The segment bus changes in the same cycle as the enables. At the first sample after a digit switch, the bus already shows the new digit's glyph.
- R9: When a key strobe and a refresh toggle fall on the same edge, both take effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_valid | input | 1 | One-cycle strobe marking a new accepted key |
| key_code | input | 4 | Hex code of the new key, sampled with `key_valid` |
| seg_n | output | 7 | Shared active-low segments {g,f,e,d,c,b,a} |
| dig_en_n | output | 2 | Active-low per-digit enables, bit 0 = newest digit |

## Verification
The bench pushes all sixteen codes in a shuffled order and checks every glyph on both digits. A decoder with a swapped entry, or history slots wired the wrong way round, would show up there. It checks the first sample after each digit switch, so a segment path delayed by one register would show the previous digit's glyph and be caught. It wiggles `key_code` while no strobe is present, so a load that ignores the strobe would change a digit. It also lines up a strobe with a refresh toggle, and it measures the exact refresh period after reset, so an off-by-one divider or a lost update is reported.

// File: rtl/keydisp_pkg.sv
// Shared types and the hex glyph function for the key display.
// Assumes segment order {g,f,e,d,c,b,a}; patterns here are active high.
package keydisp_pkg;

    localparam int CODE_W = 4;

    typedef logic [6:0] seg_t;

    // Maps a 4-bit code to its active-high hex glyph.
    function automatic seg_t hex_glyph(input logic [CODE_W-1:0] code);
        seg_t g;
        case (code)
            4'h0: g = 7'h3F;
            4'h1: g = 7'h06;
            4'h2: g = 7'h5B;
            4'h3: g = 7'h4F;
            4'h4: g = 7'h66;
            4'h5: g = 7'h6D;
            4'h6: g = 7'h7D;
            4'h7: g = 7'h07;
            4'h8: g = 7'h7F;
            4'h9: g = 7'h6F;
            4'hA: g = 7'h77;
            4'hB: g = 7'h7C;
            4'hC: g = 7'h39;
            4'hD: g = 7'h5E;
            4'hE: g = 7'h79;
            default: g = 7'h71;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/keydisp_history.sv
// Two-deep shift history of key codes.
// Assumes key_valid is a single-cycle strobe per accepted key.
module keydisp_history #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CODE_W-1:0] key_code,
    output logic [CODE_W-1:0] newest,
    output logic [CODE_W-1:0] older
);

    // Shift the newest code into the older slot and load the new code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            newest <= '0;
            older  <= '0;
        end else if (key_valid) begin
            older  <= newest;
            newest <= key_code;
        end
    end

    // R2
    shift_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> (newest == $past(key_code)) && (older == $past(newest)));

    // R3
    hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |=> $stable(newest) && $stable(older));

endmodule

// File: rtl/keydisp_refresh.sv
// Refresh divider and digit selector.
// Toggles sel once every DIV clock edges; the counter restarts on reset.
module keydisp_refresh #(
    parameter int DIV = 200000
) (
    input  logic clk,
    input  logic rst_n,
    output logic sel
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;
    logic          tick;

    // Marks the last cycle of each refresh period.
    always_comb tick = (cnt == LAST);

    // Count the refresh period and wrap at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || tick) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    // Toggle the selected digit at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)    sel <= 1'b0;
        else if (tick) sel <= ~sel;
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R6
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sel));

    // R6
    sel_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (sel != $past(sel)));

endmodule

// File: rtl/keydisp_hexseg.sv
// Hex-to-seven-segment decoder with a selectable output polarity.
// Assumes segment order {g,f,e,d,c,b,a}.
module keydisp_hexseg
    import keydisp_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  logic [CODE_W-1:0] code,
    output seg_t              seg
);

    seg_t lit;

    // Look up the active-high glyph for the code.
    always_comb lit = hex_glyph(code);

    generate
        if (ACTIVE_LOW) begin : g_low
            // Invert the glyph for active-low segment lines.
            always_comb seg = ~lit;
        end else begin : g_high
            // Pass the glyph through for active-high segment lines.
            always_comb seg = lit;
        end
    endgenerate

endmodule

// File: rtl/keydisp_top.sv
// Two-digit multiplexed display of the last two key codes.
// Assumes a one-cycle key_valid strobe and synchronous active-low reset.
// Digit 0 shows the newest code, digit 1 the previous one.
module keydisp_top
    import keydisp_pkg::*;
#(
    parameter int REFRESH_DIV = 200000,
    parameter bit SEG_LOW     = 1'b1,
    parameter bit EN_LOW      = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_valid,
    input  logic [3:0]  key_code,
    output logic [6:0]  seg_n,
    output logic [1:0]  dig_en_n
);

    logic [CODE_W-1:0] newest;
    logic [CODE_W-1:0] older;
    logic [CODE_W-1:0] shown;
    logic              sel;
    logic [1:0]        en_hi;

    keydisp_history #(.CODE_W(CODE_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_code  (key_code),
        .newest    (newest),
        .older     (older)
    );

    keydisp_refresh #(.DIV(REFRESH_DIV)) u_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel)
    );

    // Pick the code that belongs to the enabled digit.
    always_comb shown = sel ? older : newest;

    keydisp_hexseg #(.ACTIVE_LOW(SEG_LOW)) u_dec (
        .code (shown),
        .seg  (seg_n)
    );

    // One-hot active-high enable for the selected digit.
    always_comb en_hi = sel ? 2'b10 : 2'b01;

    generate
        if (EN_LOW) begin : g_en_low
            // Drive the enables active low for transistor switching.
            always_comb dig_en_n = ~en_hi;
        end else begin : g_en_high
            // Drive the enables active high.
            always_comb dig_en_n = en_hi;
        end
    endgenerate

    // R5
    one_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dig_en_n ^ {2{EN_LOW}}) == 1);

    // R8
    seg_follows_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(dig_en_n) && $stable(newest) && $stable(older) |-> $stable(seg_n));

endmodule

// File: tb/sim_keydisp_top.sv
module sim_keydisp_top;

    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_valid = 1'b0;
    logic [3:0] key_code = 4'h0;
    logic [6:0] seg_n;
    logic [1:0] dig_en_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // {code, active-low glyph}, shuffled order
    localparam logic [10:0] VEC [16] = '{
        {4'h7, 7'h78}, {4'hA, 7'h08}, {4'h0, 7'h40}, {4'hF, 7'h0E},
        {4'h3, 7'h30}, {4'hB, 7'h03}, {4'hC, 7'h46}, {4'h5, 7'h12},
        {4'hD, 7'h21}, {4'h1, 7'h79}, {4'hE, 7'h06}, {4'h8, 7'h00},
        {4'h2, 7'h24}, {4'h9, 7'h10}, {4'h6, 7'h02}, {4'h4, 7'h19}
    };

    always #10 clk = ~clk;

    keydisp_top #(.REFRESH_DIV(DIV)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_valid (key_valid),
        .key_code  (key_code),
        .seg_n     (seg_n),
        .dig_en_n  (dig_en_n)
    );

    function automatic logic [6:0] glyph(input logic [3:0] c);
        logic [6:0] g = 7'h7F;
        for (int i = 0; i < 16; i++)
            if (VEC[i][10:7] == c) g = VEC[i][6:0];
        return g;
    endfunction

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Wait until the target digit becomes enabled, returning at the first sample after the switch.
    task automatic wait_digit(input int d);
        logic [1:0] tgt = (d == 0) ? 2'b10 : 2'b01;
        int n = 0;
        while (dig_en_n === tgt && n < 4 * DIV) begin
            @(negedge clk);
            n++;
        end
        n = 0;
        while (dig_en_n !== tgt && n < 4 * DIV) begin
            @(negedge clk);
            n++;
            if ($countones(~dig_en_n) != 1) begin
                checks++;
                errors++;
                $display("FAIL R5: actual=%b expected=one low", dig_en_n);
            end
        end
        if (dig_en_n !== tgt) chk("R6 digit never enabled", {5'b0, dig_en_n}, {5'b0, tgt});
    endtask

    task automatic push(input logic [3:0] c);
        key_valid = 1'b1;
        key_code  = c;
        @(negedge clk);
        key_valid = 1'b0;
        key_code  = ~c;
    endtask

    task automatic summary;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [3:0] exp_new;
        logic [3:0] exp_old;
        int k;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 enables", {5'b0, dig_en_n}, 7'b0000010);
        chk("R1 seg", seg_n, 7'h40);

        // R6: first toggle exactly DIV edges after release
        rst_n = 1'b1;
        k = 0;
        while (dig_en_n === 2'b10 && k < 4 * DIV) begin
            @(negedge clk);
            k++;
        end
        chk("R6 first toggle", 7'(k), 7'(DIV));
        chk("R1 older zero", seg_n, 7'h40);
        // R6: one full period between toggles
        k = 0;
        while (dig_en_n === 2'b01 && k < 4 * DIV) begin
            @(negedge clk);
            k++;
        end
        chk("R6 period", 7'(k), 7'(DIV));

        // Vector table: R2, R4, R7, R8
        exp_new = 4'h0;
        for (int i = 0; i < 16; i++) begin
            push(VEC[i][10:7]);
            exp_old = exp_new;
            exp_new = VEC[i][10:7];
            wait_digit(0);
            chk("R4/R7/R8 newest", seg_n, VEC[i][6:0]);
            wait_digit(1);
            chk("R2/R4/R8 older", seg_n, glyph(exp_old));
        end

        // R3: code changes without strobe
        for (int j = 0; j < 3 * DIV; j++) begin
            key_code = 4'(j);
            @(negedge clk);
        end
        wait_digit(0);
        chk("R3 newest held", seg_n, glyph(exp_new));
        wait_digit(1);
        chk("R3 older held", seg_n, glyph(exp_old));

        // R9: strobe on the same edge as a refresh toggle
        wait_digit(0);
        repeat (DIV - 1) @(negedge clk);
        push(4'hD);
        exp_old = exp_new;
        exp_new = 4'hD;
        chk("R9 toggled", {5'b0, dig_en_n}, 7'b0000001);
        chk("R9 older shifted", seg_n, glyph(exp_old));
        wait_digit(0);
        chk("R9 newest loaded", seg_n, 7'h21);

        // R2: back-to-back strobes shift twice
        push(4'h1);
        push(4'hF);
        wait_digit(0);
        chk("R2 back-to-back newest", seg_n, 7'h0E);
        wait_digit(1);
        chk("R2 back-to-back older", seg_n, 7'h79);

        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid-run enables", {5'b0, dig_en_n}, 7'b0000010);
        chk("R1 mid-run seg", seg_n, 7'h40);
        rst_n = 1'b1;
        wait_digit(1);
        chk("R1 mid-run older", seg_n, 7'h40);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule